// File: doc/BRIEF.md
# BCD Calendar Time Counter

This core keeps wall-clock time for a chip from a slow, fixed-rate tick (nominally 128 pulses per second, each pulse one clock cycle wide). A binary sub-second counter divides the tick down to whole seconds. A chain of packed-BCD counters then carries from seconds through minutes, hours, weekday, day of month and month into the year. Months have their proper lengths, and February follows a plain divisible-by-four leap rule.

Software reaches every counter and two control registers through a simple indexed register bus. Writes are synchronous and reads are combinational. To set the clock, software stops counting and holds the prescaler in reset, writes the fields, and then releases the prescaler and starts the clock in a single control write. A 30-second adjust rounds the seconds field to the nearest minute.

A carry flag is raised on every seconds advance. Software clears the flag, reads the time fields, and then checks the flag again: if it is set, a rollover happened during the multi-register read and the read must be repeated. With its enable set, the flag also drives an interrupt output.

Top module: `rtc_core`

## Requirements
- R1: After synchronous reset, seconds, minutes, hours, weekday and year read 0. Day of month and month read 01. Both control registers and the sub-second counter read 0, and the interrupt output is low.
- R2: Register index 0 reads the sub-second counter. It adds one per tick only while control 2 bit 0 (start) and bit 3 (enable) are 1 and bit 1 (prescaler reset) is 0. While bit 1 is 1 it is cleared and held at 0. At any other time it holds its value.
- R3: Each wrap of the sub-second counter from 127 to 0 advances the seconds counter (index 1). Seconds (index 1) and minutes (index 2) run 00 to 59 and carry into the next field. Hours (index 3) run 00 to 23 and carry into the day.
- R4: A write to indices 1 to 7 loads the field only while start is 0 and prescaler reset is 1. Otherwise the write is ignored. A write to index 0 is always ignored.
- R5: On each day advance the weekday (index 4) counts 0 to 6 and wraps from 6 to 0.
- R6: The day of month (index 5) wraps to 01 after 31, 30 (months 04, 06, 09, 11), 28, or 29 (month 02 when the two low year digits are divisible by four).
- R7: The month (index 6) runs 01 to 12 and carries into the year (index 7). The year is four BCD digits in 16 bits. The low byte wraps 99 to 00 and carries into the century byte, so 9999 wraps to 0000.
- R8: Writing control 2 (index 15) with bit 2 set clears the seconds to 00. If the seconds were 30 or more, it also advances the minutes through the normal carry chain. Bit 2 always reads 0.
- R9: Control 1 (index 14) bit 7, the carry flag, is set on every seconds advance caused by the tick. A write with bit 7 = 0 clears it, and a write with bit 7 = 1 leaves it unchanged. A tick-driven set wins over a clear in the same cycle.
- R10: The output carry_irq_o is high exactly while the carry flag and control 1 bit 4 (carry interrupt enable) are both 1.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Core clock |
| rst | input | 1 | Synchronous active-high reset |
| tick_i | input | 1 | One-cycle pulse at the sub-second rate |
| wr_en_i | input | 1 | Register write strobe |
| addr_i | input | 4 | Register index |
| wdata_i | input | 16 | Write data; only the year uses bits 15:8 |
| rdata_o | output | 16 | Combinational read data for addr_i |
| carry_irq_o | output | 1 | Carry interrupt request |

## Verification
The hardest situation to reach is a seconds rollover that lands between software clearing the carry flag and reading it back, which is the torn-read case the flag exists for. The bench first pins the tick phase by holding the prescaler in reset. It then clears the flag, feeds exactly 127 ticks and shows the flag still clear, and feeds one more tick to show the flag and the interrupt both rise. The deep calendar carries (leap day, century wrap) are reached by loading the fields one second before the boundary and supplying exactly 128 ticks.

// File: rtl/rtc_pkg.sv
package rtc_pkg;

    // register indices the bus decodes
    localparam logic [3:0] IDX_SUB   = 4'd0;
    localparam logic [3:0] IDX_SEC   = 4'd1;
    localparam logic [3:0] IDX_MIN   = 4'd2;
    localparam logic [3:0] IDX_HOUR  = 4'd3;
    localparam logic [3:0] IDX_WDAY  = 4'd4;
    localparam logic [3:0] IDX_MDAY  = 4'd5;
    localparam logic [3:0] IDX_MON   = 4'd6;
    localparam logic [3:0] IDX_YEAR  = 4'd7;
    localparam logic [3:0] IDX_CTL1  = 4'd14;
    localparam logic [3:0] IDX_CTL2  = 4'd15;

    // control bit positions
    localparam int B_CF    = 7;
    localparam int B_CIE   = 4;
    localparam int B_START = 0;
    localparam int B_PRST  = 1;
    localparam int B_ADJ   = 2;
    localparam int B_EN    = 3;

    typedef struct packed {
        logic [15:0] year;
        logic [7:0]  mon;
        logic [7:0]  mday;
        logic [7:0]  wday;
        logic [7:0]  hour;
        logic [7:0]  min;
        logic [7:0]  sec;
    } cal_t;

    localparam cal_t CAL_RESET = '{year: 16'h0000, mon: 8'h01, mday: 8'h01,
                                   wday: 8'h00, hour: 8'h00, min: 8'h00, sec: 8'h00};

    // next packed-BCD value in the range lo..hi, wrapping at or above hi
    function automatic logic [7:0] bcd_step(input logic [7:0] v,
                                            input logic [7:0] lo,
                                            input logic [7:0] hi);
        if (v >= hi)          return lo;
        if (v[3:0] >= 4'd9)   return {v[7:4] + 4'd1, 4'd0};
        return v + 8'd1;
    endfunction

    // two BCD digits divisible by four
    function automatic logic leap_yr(input logic [7:0] yl);
        if (yl[4]) return (yl[3:0] == 4'd2) || (yl[3:0] == 4'd6);
        return (yl[3:0] == 4'd0) || (yl[3:0] == 4'd4) || (yl[3:0] == 4'd8);
    endfunction

    function automatic logic [7:0] month_len(input logic [7:0] mon,
                                             input logic [7:0] yl);
        case (mon)
            8'h02:                      return leap_yr(yl) ? 8'h29 : 8'h28;
            8'h04, 8'h06, 8'h09, 8'h11: return 8'h30;
            default:                    return 8'h31;
        endcase
    endfunction

endpackage

// File: rtl/rtc_prescaler.sv
module rtc_prescaler #(
    parameter int SUB_W = 7
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             tick_i,
    input  logic             run_i,
    input  logic             prst_i,
    output logic [SUB_W-1:0] sub_o,
    output logic             sec_pulse_o
);
    localparam logic [SUB_W-1:0] SUB_LAST = {SUB_W{1'b1}};

    logic [SUB_W-1:0] sub_q;

    always_ff @(posedge clk) begin
        if (rst || prst_i)          sub_q <= '0;
        else if (tick_i && run_i)   sub_q <= sub_q + 1'b1;
    end

    assign sub_o       = sub_q;
    assign sec_pulse_o = tick_i && run_i && !prst_i && (sub_q == SUB_LAST);

    p_prst_holds_r2: assert property (@(posedge clk) disable iff (rst)
        prst_i |=> (sub_q == '0));

    p_stopped_stable_r2: assert property (@(posedge clk) disable iff (rst)
        (!run_i && !prst_i) |=> $stable(sub_q));

endmodule

// File: rtl/rtc_calendar.sv
module rtc_calendar
    import rtc_pkg::*;
#(
    parameter bit WIDE_YEAR = 1'b1
) (
    input  logic        clk,
    input  logic        rst,
    input  logic        step_i,
    input  logic        adj_i,
    input  logic        ld_en_i,
    input  logic [2:0]  ld_idx_i,
    input  logic [15:0] ld_data_i,
    output cal_t        cal_o
);
    cal_t cur, nx;
    logic c_min, c_hr, c_day, c_mon, c_yr;
    logic [7:0] mlen;

    always_comb begin
        nx    = cur;
        c_min = 1'b0;
        c_hr  = 1'b0;
        c_day = 1'b0;
        c_mon = 1'b0;
        c_yr  = 1'b0;
        mlen  = month_len(cur.mon, cur.year[7:0]);

        if (adj_i) begin
            nx.sec = 8'h00;
            c_min  = (cur.sec >= 8'h30);
        end else if (step_i) begin
            nx.sec = bcd_step(cur.sec, 8'h00, 8'h59);
            c_min  = (cur.sec >= 8'h59);
        end
        if (c_min) begin
            nx.min = bcd_step(cur.min, 8'h00, 8'h59);
            c_hr   = (cur.min >= 8'h59);
        end
        if (c_hr) begin
            nx.hour = bcd_step(cur.hour, 8'h00, 8'h23);
            c_day   = (cur.hour >= 8'h23);
        end
        if (c_day) begin
            nx.wday = bcd_step(cur.wday, 8'h00, 8'h06);
            nx.mday = bcd_step(cur.mday, 8'h01, mlen);
            c_mon   = (cur.mday >= mlen);
        end
        if (c_mon) begin
            nx.mon = bcd_step(cur.mon, 8'h01, 8'h12);
            c_yr   = (cur.mon >= 8'h12);
        end
        if (c_yr) begin
            nx.year[7:0] = bcd_step(cur.year[7:0], 8'h00, 8'h99);
            if (WIDE_YEAR && (cur.year[7:0] >= 8'h99))
                nx.year[15:8] = bcd_step(cur.year[15:8], 8'h00, 8'h99);
        end

        if (ld_en_i) begin
            case (ld_idx_i)
                3'd1: nx.sec  = ld_data_i[7:0];
                3'd2: nx.min  = ld_data_i[7:0];
                3'd3: nx.hour = ld_data_i[7:0];
                3'd4: nx.wday = ld_data_i[7:0];
                3'd5: nx.mday = ld_data_i[7:0];
                3'd6: nx.mon  = ld_data_i[7:0];
                3'd7: nx.year = WIDE_YEAR ? ld_data_i : {8'h00, ld_data_i[7:0]};
                default: ;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (rst) cur <= CAL_RESET;
        else     cur <= nx;
    end

    assign cal_o = cur;

    p_sec_wrap_r3: assert property (@(posedge clk) disable iff (rst)
        (step_i && !adj_i && !ld_en_i && cur.sec == 8'h59) |=> (cur.sec == 8'h00));

    p_adj_clears_r8: assert property (@(posedge clk) disable iff (rst)
        (adj_i && !ld_en_i) |=> (cur.sec == 8'h00));

    p_month_range_r7: assert property (@(posedge clk) disable iff (rst)
        (c_yr && !ld_en_i) |=> (cur.mon == 8'h01));

endmodule

// File: rtl/rtc_core.sv
module rtc_core
    import rtc_pkg::*;
#(
    parameter int SUB_W     = 7,
    parameter bit WIDE_YEAR = 1'b1
) (
    input  logic        clk,
    input  logic        rst,
    input  logic        tick_i,
    input  logic        wr_en_i,
    input  logic [3:0]  addr_i,
    input  logic [15:0] wdata_i,
    output logic [15:0] rdata_o,
    output logic        carry_irq_o
);
    localparam int PAD_W = 16 - SUB_W;

    logic start_q, prst_q, en_q, cf_q, cie_q;
    logic run, sec_pulse, adj, ld_en, wr_c1, wr_c2;
    logic [SUB_W-1:0] sub;
    cal_t cal;

    assign wr_c1 = wr_en_i && (addr_i == IDX_CTL1);
    assign wr_c2 = wr_en_i && (addr_i == IDX_CTL2);
    assign adj   = wr_c2 && wdata_i[B_ADJ];
    assign run   = start_q && en_q && !prst_q;
    assign ld_en = wr_en_i && !start_q && prst_q &&
                   (addr_i >= IDX_SEC) && (addr_i <= IDX_YEAR);

    always_ff @(posedge clk) begin
        if (rst) begin
            start_q <= 1'b0;
            prst_q  <= 1'b0;
            en_q    <= 1'b0;
            cie_q   <= 1'b0;
            cf_q    <= 1'b0;
        end else begin
            if (wr_c2) begin
                start_q <= wdata_i[B_START];
                prst_q  <= wdata_i[B_PRST];
                en_q    <= wdata_i[B_EN];
            end
            if (wr_c1) cie_q <= wdata_i[B_CIE];
            if (sec_pulse)                      cf_q <= 1'b1;
            else if (wr_c1 && !wdata_i[B_CF])   cf_q <= 1'b0;
        end
    end

    rtc_prescaler #(.SUB_W(SUB_W)) u_pre (
        .clk(clk), .rst(rst), .tick_i(tick_i), .run_i(run),
        .prst_i(prst_q), .sub_o(sub), .sec_pulse_o(sec_pulse)
    );

    rtc_calendar #(.WIDE_YEAR(WIDE_YEAR)) u_cal (
        .clk(clk), .rst(rst), .step_i(sec_pulse), .adj_i(adj),
        .ld_en_i(ld_en), .ld_idx_i(addr_i[2:0]), .ld_data_i(wdata_i),
        .cal_o(cal)
    );

    always_comb begin
        rdata_o = 16'h0000;
        case (addr_i)
            IDX_SUB:  rdata_o = {{PAD_W{1'b0}}, sub};
            IDX_SEC:  rdata_o = {8'h00, cal.sec};
            IDX_MIN:  rdata_o = {8'h00, cal.min};
            IDX_HOUR: rdata_o = {8'h00, cal.hour};
            IDX_WDAY: rdata_o = {8'h00, cal.wday};
            IDX_MDAY: rdata_o = {8'h00, cal.mday};
            IDX_MON:  rdata_o = {8'h00, cal.mon};
            IDX_YEAR: rdata_o = cal.year;
            IDX_CTL1: rdata_o = {8'h00, cf_q, 2'b00, cie_q, 4'b0000};
            IDX_CTL2: rdata_o = {12'h000, en_q, 1'b0, prst_q, start_q};
            default:  rdata_o = 16'h0000;
        endcase
    end

    assign carry_irq_o = cf_q && cie_q;

    p_cf_on_second_r9: assert property (@(posedge clk) disable iff (rst)
        sec_pulse |=> cf_q);

    p_irq_needs_enable_r10: assert property (@(posedge clk) disable iff (rst)
        !cie_q |-> !carry_irq_o);

    p_no_count_in_setup_r4: assert property (@(posedge clk) disable iff (rst)
        (prst_q && !start_q) |-> !sec_pulse);

endmodule

// File: tb/tb_rtc_core.sv
module tb_rtc_core;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        tick = 1'b0;
    logic        wr_en = 1'b0;
    logic [3:0]  addr = 4'd0;
    logic [15:0] wdata = 16'h0;
    logic [15:0] rdata;
    logic        irq;

    always #5 clk = ~clk;

    rtc_core dut (
        .clk(clk), .rst(rst), .tick_i(tick), .wr_en_i(wr_en),
        .addr_i(addr), .wdata_i(wdata), .rdata_o(rdata), .carry_irq_o(irq)
    );

    typedef struct {
        bit          is_irq;
        logic [15:0] exp;
        string       tag;
    } item_t;

    item_t q[$];
    item_t it;
    int n_chk = 0;
    int n_fail = 0;
    bit finished = 1'b0;

    // monitor: compares half a cycle after the driver sets the index
    always @(negedge clk) begin
        if (q.size() != 0) begin
            logic [15:0] act;
            it  = q.pop_front();
            act = it.is_irq ? {15'h0, irq} : rdata;
            n_chk++;
            if (act !== it.exp) begin
                n_fail++;
                $display("FAIL %s: actual %h expected %h", it.tag, act, it.exp);
            end
        end
    end

    task automatic expect_reg(input logic [3:0] a, input logic [15:0] e, input string tag);
        item_t x;
        @(posedge clk); #1;
        addr = a;
        x.is_irq = 1'b0; x.exp = e; x.tag = tag;
        q.push_back(x);
    endtask

    task automatic expect_irq(input bit e, input string tag);
        item_t x;
        @(posedge clk); #1;
        x.is_irq = 1'b1; x.exp = {15'h0, e}; x.tag = tag;
        q.push_back(x);
    endtask

    task automatic wr(input logic [3:0] a, input logic [15:0] d);
        @(posedge clk); #1;
        wr_en = 1'b1; addr = a; wdata = d;
        @(posedge clk); #1;
        wr_en = 1'b0;
    endtask

    task automatic ticks(input int n);
        for (int i = 0; i < n; i++) begin
            @(posedge clk); #1; tick = 1'b1;
            @(posedge clk); #1; tick = 1'b0;
        end
    endtask

    task automatic set_time(input logic [15:0] yr, input logic [7:0] mo, input logic [7:0] md,
                            input logic [7:0] wd, input logic [7:0] hr, input logic [7:0] mi,
                            input logic [7:0] se);
        wr(4'd15, 16'h0002);
        wr(4'd1, {8'h0, se});
        wr(4'd2, {8'h0, mi});
        wr(4'd3, {8'h0, hr});
        wr(4'd4, {8'h0, wd});
        wr(4'd5, {8'h0, md});
        wr(4'd6, {8'h0, mo});
        wr(4'd7, yr);
        wr(4'd15, 16'h0009);
    endtask

    task automatic report;
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    endtask

    initial begin
        #2_000_000;
        if (!finished) begin
            n_chk++; n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            report();
        end
    end

    initial begin
        repeat (4) @(posedge clk);
        #1 rst = 1'b0;

        // R1 reset state
        expect_reg(4'd0, 16'h0000, "R1 subsec");
        expect_reg(4'd1, 16'h0000, "R1 sec");
        expect_reg(4'd5, 16'h0001, "R1 mday");
        expect_reg(4'd6, 16'h0001, "R1 month");
        expect_reg(4'd7, 16'h0000, "R1 year");
        expect_reg(4'd14, 16'h0000, "R1 ctl1");
        expect_reg(4'd15, 16'h0000, "R1 ctl2");
        expect_irq(1'b0, "R1 irq");

        // R3 R5 R6 R7 full day carry into March of a common year
        set_time(16'h2023, 8'h02, 8'h28, 8'h06, 8'h23, 8'h59, 8'h58);
        expect_reg(4'd15, 16'h0009, "R4 ctl2 running");
        ticks(128);
        expect_reg(4'd1, 16'h0059, "R3 sec step");
        expect_reg(4'd2, 16'h0059, "R3 min hold");
        ticks(128);
        expect_reg(4'd1, 16'h0000, "R3 sec wrap");
        expect_reg(4'd2, 16'h0000, "R3 min wrap");
        expect_reg(4'd3, 16'h0000, "R3 hour wrap");
        expect_reg(4'd4, 16'h0000, "R5 weekday wrap");
        expect_reg(4'd5, 16'h0001, "R6 feb common");
        expect_reg(4'd6, 16'h0003, "R6 month step");
        expect_reg(4'd7, 16'h2023, "R7 year hold");

        // R4 write ignored while running; index 0 never written
        wr(4'd1, 16'h0011);
        expect_reg(4'd1, 16'h0000, "R4 ignored running");
        wr(4'd15, 16'h0002);
        wr(4'd0, 16'h0055);
        expect_reg(4'd0, 16'h0000, "R4 index0 ignored");

        // R6 leap year
        set_time(16'h2024, 8'h02, 8'h28, 8'h03, 8'h23, 8'h59, 8'h59);
        ticks(128);
        expect_reg(4'd5, 16'h0029, "R6 leap 29th");
        expect_reg(4'd4, 16'h0004, "R5 weekday step");
        set_time(16'h2024, 8'h02, 8'h29, 8'h04, 8'h23, 8'h59, 8'h59);
        ticks(128);
        expect_reg(4'd5, 16'h0001, "R6 leap wrap");
        expect_reg(4'd6, 16'h0003, "R6 leap month");
        set_time(16'h2023, 8'h04, 8'h30, 8'h01, 8'h23, 8'h59, 8'h59);
        ticks(128);
        expect_reg(4'd5, 16'h0001, "R6 30-day wrap");
        expect_reg(4'd6, 16'h0005, "R6 30-day month");

        // R7 century wrap
        set_time(16'h9999, 8'h12, 8'h31, 8'h06, 8'h23, 8'h59, 8'h59);
        ticks(128);
        expect_reg(4'd7, 16'h0000, "R7 century wrap");
        expect_reg(4'd6, 16'h0001, "R7 month wrap");
        expect_reg(4'd5, 16'h0001, "R7 mday wrap");
        set_time(16'h1999, 8'h12, 8'h31, 8'h00, 8'h23, 8'h59, 8'h59);
        ticks(128);
        expect_reg(4'd7, 16'h2000, "R7 low carry");

        // R8 30-second adjust
        wr(4'd15, 16'h0002);
        wr(4'd1, 16'h0029);
        wr(4'd2, 16'h0010);
        wr(4'd15, 16'h0006);
        expect_reg(4'd1, 16'h0000, "R8 round down sec");
        expect_reg(4'd2, 16'h0010, "R8 round down min");
        expect_reg(4'd15, 16'h0002, "R8 adj reads 0");
        wr(4'd1, 16'h0045);
        wr(4'd15, 16'h0006);
        expect_reg(4'd1, 16'h0000, "R8 round up sec");
        expect_reg(4'd2, 16'h0011, "R8 round up min");

        // R9 R10 carry flag and interrupt
        set_time(16'h2023, 8'h06, 8'h15, 8'h02, 8'h10, 8'h20, 8'h00);
        wr(4'd14, 16'h0010);
        expect_reg(4'd14, 16'h0010, "R9 cf clear");
        ticks(127);
        expect_reg(4'd14, 16'h0010, "R9 no carry before wrap");
        expect_irq(1'b0, "R10 irq low");
        ticks(1);
        expect_reg(4'd14, 16'h0090, "R9 carry set");
        expect_irq(1'b1, "R10 irq high");
        expect_reg(4'd1, 16'h0001, "R3 sec after carry");
        wr(4'd14, 16'h0090);
        expect_reg(4'd14, 16'h0090, "R9 write1 no effect");
        wr(4'd14, 16'h0010);
        expect_reg(4'd14, 16'h0010, "R9 write0 clears");
        expect_irq(1'b0, "R10 irq follows cf");
        wr(4'd14, 16'h0000);
        ticks(128);
        expect_reg(4'd14, 16'h0080, "R9 carry no enable");
        expect_irq(1'b0, "R10 irq masked");

        // R2 stop, run and prescaler reset
        wr(4'd15, 16'h0008);
        ticks(5);
        expect_reg(4'd0, 16'h0000, "R2 stopped subsec");
        expect_reg(4'd1, 16'h0002, "R2 stopped sec");
        wr(4'd15, 16'h0009);
        ticks(5);
        expect_reg(4'd0, 16'h0005, "R2 running subsec");
        wr(4'd15, 16'h000B);
        ticks(3);
        expect_reg(4'd0, 16'h0000, "R2 prescaler reset");
        expect_reg(4'd15, 16'h000B, "R2 ctl2 readback");

        repeat (3) @(posedge clk);
        finished = 1'b1;
        report();
    end

endmodule